// File: doc/BRIEF.md
# Masked Priority Interrupt Entry Sequencer

This block sits beside a processor core and handles the hardware side of taking an interrupt. It holds twelve interrupt categories in pending latches. At each instruction boundary it compares them against the enable bits of a 16-bit program status word, and only while a master enable is set. When a category is accepted, the block clears the master enable and reads a handler pointer from a memory location fixed for that category. It saves the program counter at the pointer and the accumulator at the word after it. It then hands the core a new program counter, which is the pointer plus two, together with a new accumulator value that depends on the category.

Category 0 is the trap. It comes from the core as a trap-executed flag plus an 8-bit constant field sampled at the instruction boundary. The other eleven categories come from request lines, and category 11 is the external-device class. A trap whose enable bit is clear raises no interrupt. Its constant is still returned for loading into the accumulator, with the upper byte cleared. While the block is busy with an entry, the core is assumed to be stalled. Instruction decode and handler software are outside the block.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset the master enable, `busy`, `mem_req`, `done` and `acc_ld` are all low, and no category is pending.
- R2: When several enabled categories are pending at an accepted boundary, the lowest-numbered one is taken (category 0, the trap, is highest).
- R3: PSW bit i (i = 0..11) enables category i when 1. A pending category whose bit is 0 is not taken but stays pending. PSW bits 12..15 never cause or block an entry.
- R4: Pending categories are compared only in a cycle with `instr_end` high, `busy` low and the master enable set. Otherwise every request stays pending.
- R5: `mie_set` sets the master enable for the next cycle. Accepting an entry, or `mie_clr`, clears it, and clearing wins. After an accepting edge `mie` is low.
- R6: In the cycle after the accepting edge, the block issues a memory read (`mem_req`=1, `mem_we`=0) at the location parameter of the accepted category. Memory returns data one cycle after a read.
- R7: The pointer read back is used as an address. The sampled program counter is written there in the third cycle after acceptance, and the sampled accumulator is written at pointer+1 in the fourth.
- R8: In the fifth cycle after acceptance, `done` pulses for one cycle with `new_pc` = pointer+2 and `entry_cat` = the accepted category. `busy` is low in the following cycle.
- R9: `new_acc` is {8'h00, trap field} for category 0, `ext_data` sampled at acceptance for category 11, and the sampled accumulator for all other categories.
- R10: A trap executed while PSW bit 0 is clear causes no entry. In the following cycle `acc_ld` pulses with `acc_ld_data` = {8'h00, trap field}.
- R11: A one-cycle request pulse is held pending until its category is accepted.
- R12: `instr_end` is ignored while `busy` is high. A request pending at that time is taken only at a later boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req | input | 11 | Request lines for categories 1..11 (bit i = category i) |
| psw | input | 16 | Program status word; bits 0..11 are category enables |
| mie_set | input | 1 | Set master interrupt enable |
| mie_clr | input | 1 | Clear master interrupt enable |
| mie | output | 1 | Master interrupt enable state |
| instr_end | input | 1 | Instruction boundary strobe |
| trap_exec | input | 1 | A trap instruction completes at this boundary |
| trap_d | input | 8 | Trap constant field |
| cur_pc | input | 16 | Program counter of the next instruction |
| cur_acc | input | 16 | Current accumulator |
| ext_data | input | 16 | External device data word |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after a read |
| acc_ld | output | 1 | Load accumulator with `acc_ld_data` (trap not taken) |
| acc_ld_data | output | 16 | Accumulator value for a trap that is not taken |
| done | output | 1 | Entry complete strobe |
| new_pc | output | 16 | Handler start address, valid with `done` |
| new_acc | output | 16 | New accumulator, valid with `done` |
| entry_cat | output | 4 | Accepted category, valid with `done` |
| busy | output | 1 | Entry sequence in progress |

## Verification
Counting from the clock edge that samples an accepted `instr_end`, the pointer read appears in the next cycle. The program counter write follows two cycles later, the accumulator write one cycle after that, and `done` one cycle after the accumulator write. `acc_ld` for a trap that is not taken appears in the cycle after its boundary. The driver pushes the expected read, writes, completion and accumulator load into the queue in that order as it applies each stimulus. The monitor compares the design's memory traffic and strobes against the queue at each falling edge, so every result is matched against the slot in which it is due. It also flags any event that no stimulus predicted. Stimuli that must not start an entry are followed by a quiet window, in which `busy` must remain low, before the next stimulus.

// File: rtl/irq_entry_pkg.sv
// Shared types and defaults for the interrupt entry sequencer.
package irq_entry_pkg;

    // Entry sequence states: fetch pointer, catch it, save PC, save ACC, report.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_CATCH,
        ST_SAVE_PC,
        ST_SAVE_ACC,
        ST_DONE
    } entry_state_t;

    // Default pointer locations: twelve consecutive 16-bit words from 0x0010.
    function automatic logic [12*16-1:0] default_vec_locs();
        logic [12*16-1:0] v;
        for (int i = 0; i < 12; i++) begin
            v[i*16 +: 16] = 16'h0010 + 16'(i);
        end
        return v;
    endfunction

endpackage

// File: rtl/irq_pend_latch.sv
// Pending request latches, one per category.
// Assumes: set and clear are single-cycle; a bit is cleared only by its clear input,
// and a set in the same cycle as a clear of that bit is absorbed (it was the accepted one).
module irq_pend_latch #(
    parameter int NCAT = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCAT-1:0] set_i,
    input  logic [NCAT-1:0] clr_i,
    output logic [NCAT-1:0] pend_o
);

    for (genvar g = 0; g < NCAT; g++) begin : g_bit
        // Hold a request until its category is accepted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_o[g] <= 1'b0;
            end else begin
                pend_o[g] <= (pend_o[g] | set_i[g]) & ~clr_i[g];
            end
        end
    end

endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: lowest index wins.
// Assumes: purely combinational; IW is wide enough to hold N-1.
module irq_prio_pick #(
    parameter int N  = 12,
    parameter int IW = 4
) (
    input  logic [N-1:0]  cand_i,
    output logic [N-1:0]  grant_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);

    // Scan from the lowest priority up so the highest-priority hit is the last to write.
    always_comb begin
        grant_o = '0;
        idx_o   = '0;
        any_o   = |cand_i;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
                idx_o      = IW'(i);
            end
        end
    end

endmodule

// File: rtl/irq_entry_fsm.sv
// Memory-indirect entry sequence: read the pointer, save PC and ACC, report the handler start.
// Assumes: synchronous memory with read data valid one cycle after a read request,
// writes always accepted; start is only raised while idle.
module irq_entry_fsm
    import irq_entry_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] loc_i,
    input  logic [AW-1:0] pc_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] nacc_i,
    input  logic [CW-1:0] cat_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_wdata_o,
    input  logic [DW-1:0] mem_rdata_i,
    output logic          done_o,
    output logic [AW-1:0] new_pc_o,
    output logic [DW-1:0] new_acc_o,
    output logic [CW-1:0] cat_o,
    output logic          busy_o
);

    entry_state_t  state_q, state_d;
    logic [AW-1:0] loc_q, pc_q, ptr_q;
    logic [DW-1:0] acc_q, nacc_q;
    logic [CW-1:0] cat_q;

    // Next-state: step through the fixed sequence once started.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (start_i) state_d = ST_FETCH;
            ST_FETCH:    state_d = ST_CATCH;
            ST_CATCH:    state_d = ST_SAVE_PC;
            ST_SAVE_PC:  state_d = ST_SAVE_ACC;
            ST_SAVE_ACC: state_d = ST_DONE;
            ST_DONE:     state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Capture the entry context at the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loc_q  <= '0;
            pc_q   <= '0;
            acc_q  <= '0;
            nacc_q <= '0;
            cat_q  <= '0;
        end else if (state_q == ST_IDLE && start_i) begin
            loc_q  <= loc_i;
            pc_q   <= pc_i;
            acc_q  <= acc_i;
            nacc_q <= nacc_i;
            cat_q  <= cat_i;
        end
    end

    // Capture the handler pointer returned by memory.
    always_ff @(posedge clk) begin
        if (!rst_n)                  ptr_q <= '0;
        else if (state_q == ST_CATCH) ptr_q <= AW'(mem_rdata_i);
    end

    // Memory port driven from state only.
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = loc_q;
            end
            ST_SAVE_PC: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ptr_q;
                mem_wdata_o = DW'(pc_q);
            end
            ST_SAVE_ACC: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ptr_q + AW'(1);
                mem_wdata_o = acc_q;
            end
            default: ;
        endcase
    end

    assign done_o    = (state_q == ST_DONE);
    assign new_pc_o  = ptr_q + AW'(2);
    assign new_acc_o = nacc_q;
    assign cat_o     = cat_q;
    assign busy_o    = (state_q != ST_IDLE);

endmodule

// File: rtl/irq_entry_seq.sv
// Top: pending latches, PSW masking, master enable, priority pick, and the entry sequence.
// Assumes: the core stalls while busy is high; PSW bit i enables category i for i < NCAT;
// category 0 is the trap, category NCAT-1 is the external-device class.
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int                    NCAT     = 12,
    parameter int                    AW       = 16,
    parameter int                    DW       = 16,
    parameter int                    TW       = 8,
    parameter logic [NCAT*AW-1:0]    VEC_LOCS = default_vec_locs()
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCAT-1:1] hw_req,
    input  logic [DW-1:0]   psw,
    input  logic            mie_set,
    input  logic            mie_clr,
    output logic            mie,
    input  logic            instr_end,
    input  logic            trap_exec,
    input  logic [TW-1:0]   trap_d,
    input  logic [AW-1:0]   cur_pc,
    input  logic [DW-1:0]   cur_acc,
    input  logic [DW-1:0]   ext_data,
    output logic            mem_req,
    output logic            mem_we,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic            acc_ld,
    output logic [DW-1:0]   acc_ld_data,
    output logic            done,
    output logic [AW-1:0]   new_pc,
    output logic [DW-1:0]   new_acc,
    output logic [$clog2(NCAT)-1:0] entry_cat,
    output logic            busy
);

    localparam int CW      = $clog2(NCAT);
    localparam int EXT_CAT = NCAT - 1;

    logic [NCAT-1:0] pend, set_vec, clr_vec, cand, grant;
    logic [CW-1:0]   pick_idx;
    logic            pick_any, boundary, trap_fire, trap_raise, accept;
    logic            mie_q, acc_ld_q;
    logic [TW-1:0]   trap_d_q, trap_d_eff;
    logic [DW-1:0]   acc_ld_data_q, nacc;
    logic [AW-1:0]   loc_sel;
    logic            unused_psw_hi;

    assign unused_psw_hi = ^psw[DW-1:NCAT];

    // Boundary qualifiers and trap request.
    assign boundary   = instr_end && !busy;
    assign trap_fire  = boundary && trap_exec;
    assign trap_raise = trap_fire && psw[0];
    assign set_vec    = {hw_req, trap_raise};

    irq_pend_latch #(.NCAT(NCAT)) i_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    // Compare pending (including this cycle's requests) against the PSW enables.
    assign cand = (pend | set_vec) & psw[NCAT-1:0];

    irq_prio_pick #(.N(NCAT), .IW(CW)) i_pick (
        .cand_i  (cand),
        .grant_o (grant),
        .idx_o   (pick_idx),
        .any_o   (pick_any)
    );

    assign accept  = boundary && mie_q && pick_any;
    assign clr_vec = accept ? grant : '0;

    // Master enable: clearing by acceptance or request wins over setting.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mie_q <= 1'b0;
        else if (accept || mie_clr)  mie_q <= 1'b0;
        else if (mie_set)            mie_q <= 1'b1;
    end
    assign mie = mie_q;

    // Hold the trap field of a raised trap until it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)          trap_d_q <= '0;
        else if (trap_raise) trap_d_q <= trap_d;
    end
    assign trap_d_eff = trap_raise ? trap_d : trap_d_q;

    // Direct accumulator load for a trap that is not taken at its boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_ld_q      <= 1'b0;
            acc_ld_data_q <= '0;
        end else begin
            acc_ld_q      <= trap_fire && !(accept && grant[0]);
            acc_ld_data_q <= DW'(trap_d);
        end
    end
    assign acc_ld      = acc_ld_q;
    assign acc_ld_data = acc_ld_data_q;

    // Class-dependent new accumulator value.
    always_comb begin
        if (pick_idx == CW'(0))            nacc = DW'(trap_d_eff);
        else if (pick_idx == CW'(EXT_CAT)) nacc = ext_data;
        else                               nacc = cur_acc;
    end

    // Pointer location parameter for the picked category.
    always_comb begin
        loc_sel = '0;
        for (int i = 0; i < NCAT; i++) begin
            if (pick_idx == CW'(i)) loc_sel = VEC_LOCS[i*AW +: AW];
        end
    end

    irq_entry_fsm #(.AW(AW), .DW(DW), .CW(CW)) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (accept),
        .loc_i       (loc_sel),
        .pc_i        (cur_pc),
        .acc_i       (cur_acc),
        .nacc_i      (nacc),
        .cat_i       (pick_idx),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata),
        .done_o      (done),
        .new_pc_o    (new_pc),
        .new_acc_o   (new_acc),
        .cat_o       (entry_cat),
        .busy_o      (busy)
    );

endmodule

// File: rtl/irq_entry_chk.sv
// Protocol checker for irq_entry_seq, attached by bind.
// Assumes: observes ports only.
module irq_entry_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mie,
    input logic          busy,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic [AW-1:0] new_pc
);

    // Memory is touched only during an entry.
    assert_mem_in_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // An entry starts with the master enable already cleared.
    assert_mie_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !mie);

    // First access of an entry is the pointer read.
    assert_fetch_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mem_req && !mem_we));

    // Accumulator save lands one word above the PC save.
    assert_acc_above_pc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && $past(mem_req && mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

    // Handler start is one word above the last save.
    assert_done_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_we) && new_pc == $past(mem_addr) + AW'(1)));

    // Completion ends the entry.
    assert_done_ends_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

bind irq_entry_seq irq_entry_chk #(.AW(AW)) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mie      (mie),
    .busy     (busy),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .done     (done),
    .new_pc   (new_pc)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NCAT = 12;

    typedef struct {
        int          kind;   // 0 read, 1 write, 2 done, 3 acc load
        string       req;
        logic [15:0] a;
        logic [15:0] b;
        logic [3:0]  c;
    } exp_t;

    function automatic logic [15:0] loc_of(int i);
        return 16'h0020 + 16'(3 * i);
    endfunction
    function automatic logic [15:0] ptr_of(int i);
        return 16'h0080 + 16'(4 * i);
    endfunction
    function automatic logic [NCAT*16-1:0] tb_locs();
        logic [NCAT*16-1:0] v;
        for (int i = 0; i < NCAT; i++) v[i*16 +: 16] = loc_of(i);
        return v;
    endfunction
    localparam logic [NCAT*16-1:0] TB_LOCS = tb_locs();

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:1] hw_req = '0;
    logic [15:0] psw = '0;
    logic        mie_set = 1'b0, mie_clr = 1'b0, instr_end = 1'b0, trap_exec = 1'b0;
    logic [7:0]  trap_d = '0;
    logic [15:0] cur_pc = '0, cur_acc = '0, ext_data = '0;
    logic        mie, mem_req, mem_we, acc_ld, done, busy;
    logic [15:0] mem_addr, mem_wdata, mem_rdata, acc_ld_data, new_pc, new_acc;
    logic [3:0]  entry_cat;

    logic [15:0] ram [256];
    exp_t        expq [$];
    int          checks = 0, errors = 0;
    bit          finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq #(.VEC_LOCS(TB_LOCS)) i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .hw_req(hw_req), .psw(psw),
        .mie_set(mie_set), .mie_clr(mie_clr), .mie(mie),
        .instr_end(instr_end), .trap_exec(trap_exec), .trap_d(trap_d),
        .cur_pc(cur_pc), .cur_acc(cur_acc), .ext_data(ext_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_ld(acc_ld), .acc_ld_data(acc_ld_data),
        .done(done), .new_pc(new_pc), .new_acc(new_acc),
        .entry_cat(entry_cat), .busy(busy)
    );

    // Synchronous memory model: pointer table loaded in reset, one-cycle read latency.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCAT; i++) ram[loc_of(i)[7:0]] <= ptr_of(i);
            mem_rdata <= '0;
        end else if (mem_req) begin
            if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
            mem_rdata <= ram[mem_addr[7:0]];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    task automatic push(input int kind, input string req, input logic [15:0] a,
                        input logic [15:0] b, input logic [3:0] c);
        exp_t e;
        e.kind = kind; e.req = req; e.a = a; e.b = b; e.c = c;
        expq.push_back(e);
    endtask

    // Driver side: the full expected entry trace for one category.
    task automatic expect_entry(input int cat, input logic [15:0] newacc, input string req);
        push(0, req, loc_of(cat), 16'h0, 4'h0);
        push(1, req, ptr_of(cat), cur_pc, 4'h0);
        push(1, req, ptr_of(cat) + 16'h1, cur_acc, 4'h0);
        push(2, req, ptr_of(cat) + 16'h2, newacc, 4'(cat));
    endtask

    // Monitor: compare each produced event with the head of the queue.
    task automatic take(input int kind, input logic [15:0] a, input logic [15:0] b, input logic [3:0] c);
        exp_t e;
        if (expq.size() == 0) begin
            chk(1'b0, "unexpected event", 32'(kind), 32'hFFFF);
            return;
        end
        e = expq.pop_front();
        chk(e.kind == kind, e.req, 32'(kind), 32'(e.kind));
        if (e.kind == kind) begin
            chk(a == e.a, e.req, 32'(a), 32'(e.a));
            if (kind != 0) chk(b == e.b, e.req, 32'(b), 32'(e.b));
            if (kind == 2) chk(c == e.c, e.req, 32'(c), 32'(e.c));
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req && !mem_we) take(0, mem_addr, 16'h0, 4'h0);
            if (mem_req && mem_we)  take(1, mem_addr, mem_wdata, 4'h0);
            if (done)               take(2, new_pc, new_acc, entry_cat);
            if (acc_ld)             take(3, acc_ld_data, 16'h0, 4'h0);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask
    task automatic pulse_mie();
        mie_set = 1'b1; tick(); mie_set = 1'b0;
    endtask
    task automatic pulse_req(input int cat);
        hw_req[cat] = 1'b1; tick(); hw_req = '0;
    endtask
    task automatic end_instr();
        instr_end = 1'b1; tick(); instr_end = 1'b0; trap_exec = 1'b0;
    endtask
    task automatic wait_idle();
        for (int i = 0; i < 20 && busy; i++) tick();
        tick();
    endtask
    task automatic quiet(input int n, input string req);
        bit ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (busy) ok = 1'b0;
            tick();
        end
        chk(ok, req, 32'(busy), 32'h0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        chk(!mie && !busy && !mem_req && !done && !acc_ld, "R1 reset", 32'({mie, busy, mem_req, done, acc_ld}), 32'h0);
        rst_n = 1'b1;
        tick();
        chk(!busy && !mie, "R1 after reset", 32'({busy, mie}), 32'h0);
        quiet(2, "R1 nothing pending");

        // R2 / R6 / R7 / R8 / R9: two pulses, lower index first; old accumulator kept
        psw = 16'h0FFF;
        pulse_mie();
        chk(mie, "R5 set", 32'(mie), 32'h1);
        hw_req[3] = 1'b1; hw_req[5] = 1'b1; tick(); hw_req = '0;
        cur_pc = 16'h1234; cur_acc = 16'h5678;
        expect_entry(3, 16'h5678, "R2 priority");
        end_instr();
        chk(!mie, "R5 cleared on accept", 32'(mie), 32'h0);
        wait_idle();

        // R11: category 5 pulse still pending
        pulse_mie();
        cur_pc = 16'h2000; cur_acc = 16'h0042;
        expect_entry(5, 16'h0042, "R11 held pending");
        end_instr();
        wait_idle();

        // R4: master enable clear, boundary ignored; enable without boundary too
        pulse_req(7);
        end_instr();
        quiet(3, "R4 master off");
        pulse_mie();
        quiet(3, "R4 no boundary");
        cur_pc = 16'h3001; cur_acc = 16'hAAAA;
        expect_entry(7, 16'hAAAA, "R4 later accepted");
        end_instr();
        wait_idle();

        // R3: only PSW bits 12..15 set, request stays pending, then enabled
        pulse_mie();
        psw = 16'hF000;
        pulse_req(4);
        end_instr();
        quiet(3, "R3 masked");
        chk(mie, "R3 mie kept", 32'(mie), 32'h1);
        psw = 16'h0010;
        cur_pc = 16'h4444; cur_acc = 16'h1111;
        expect_entry(4, 16'h1111, "R3 enabled");
        end_instr();
        wait_idle();

        // R9: external category loads device data
        psw = 16'h0FFF;
        pulse_mie();
        ext_data = 16'hBEEF;
        pulse_req(11);
        cur_pc = 16'h5550; cur_acc = 16'h0F0F;
        expect_entry(11, 16'hBEEF, "R9 external");
        end_instr();
        wait_idle();

        // R9: enabled trap enters with the field in the low byte
        pulse_mie();
        cur_pc = 16'h6001; cur_acc = 16'hFFFF;
        trap_exec = 1'b1; trap_d = 8'hA5;
        expect_entry(0, 16'h00A5, "R9 trap");
        end_instr();
        wait_idle();

        // R10: masked trap loads the field directly, no entry
        psw = 16'h0FFE;
        pulse_mie();
        trap_exec = 1'b1; trap_d = 8'h3C;
        push(3, "R10 masked trap", 16'h003C, 16'h0, 4'h0);
        end_instr();
        quiet(3, "R10 no entry");
        chk(mie, "R10 mie kept", 32'(mie), 32'h1);

        // R12: boundary during an entry is ignored
        psw = 16'h0FFF;
        pulse_req(1);
        cur_pc = 16'h7000; cur_acc = 16'h7777;
        expect_entry(1, 16'h7777, "R12 first entry");
        end_instr();
        hw_req[9] = 1'b1; mie_set = 1'b1; tick(); hw_req = '0; mie_set = 1'b0;
        instr_end = 1'b1; tick(); instr_end = 1'b0;
        wait_idle();
        quiet(3, "R12 ignored while busy");
        cur_pc = 16'h7100; cur_acc = 16'h0101;
        expect_entry(9, 16'h0101, "R12 later accepted");
        end_instr();
        wait_idle();

        chk(expq.size() == 0, "all expected events seen", 32'(expq.size()), 32'h0);
        summary();
    end

endmodule